// File: doc/BRIEF.md
# Fly-by DMA transfer sequencer

This block is a single-channel DMA sequencer that moves bytes between one I/O peripheral and memory without the data ever passing through it. Software-side logic loads a start address, a byte count, a direction, a mode and a write-delay value. When the peripheral raises its request, the sequencer drives the memory address, asserts acknowledge and an address-enable flag, and then issues the I/O and memory strobes one after the other. The peripheral is picked out only by acknowledge together with an I/O strobe. The data moves directly between peripheral and memory on the shared bus.

In single mode each acknowledge carries one byte, and the bus is handed back after it so that a pending refresh can be granted. In burst mode one acknowledge carries up to eight bytes. A refresh request is honoured only between acknowledges, so a burst in progress always runs to its end. For I/O-to-memory moves, the memory write is held back by a programmable number of clocks so that the peripheral's read data has settled before the write cycle starts.

Top module: `flyby_dma_seq`

## Requirements
- R1: With cfg_dir=0 (I/O to memory), io_rd rises first and mem_wr is high for one clock, starting 1+D clocks after io_rd rose, where D is cfg_wr_delay; mem_wr is only ever high while io_rd is high.
- R2: With cfg_dir=1 (memory to I/O), mem_rd rises first and io_wr is high for one clock, exactly one clock after mem_rd rose; cfg_wr_delay has no effect in this direction.
- R3: Every strobe is high only while dack is high, mem_addr stays stable while strobes stay high, and only the two strobes of the selected direction ever pulse.
- R4: aen is high in every cycle in which dack is high.
- R5: With cfg_burst=0, each dack assertion moves exactly one byte and dack drops between bytes.
- R6: With cfg_burst=1, each dack assertion moves 8 bytes, or the remainder when fewer are left.
- R7: Both strobes of a byte drop together one clock after the second strobe; dack rises with no strobe active, and dack falls only after a cycle in which all strobes are inactive.
- R8: refresh_gnt follows refresh_req only while dack is low; a refresh request held in an idle cycle starts no new acknowledge, and a burst already running is completed before the grant.
- R9: mem_addr increments and bytes_left decrements after each byte; the address wraps modulo 2^ADDR_W.
- R10: tc is high for exactly one clock, in the last cycle of the final byte. After that no further transfer starts, and a loaded count of zero starts none.
- R11: A request that is withdrawn before it is acknowledged starts no transfer and leaves bytes_left unchanged.
- R12: cfg_load is accepted only while dack is low; a load pulse during a transfer changes neither the count nor the transfer.
- R13: rst_n low clears all outputs at once, including during a transfer; release takes effect two clocks later.

Ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_load | input | 1 | Load strobe for the configuration fields |
| cfg_addr | input | ADDR_W | Start memory address |
| cfg_count | input | CNT_W | Number of bytes to move |
| cfg_dir | input | 1 | 0: I/O to memory, 1: memory to I/O |
| cfg_burst | input | 1 | 0: single mode, 1: burst mode |
| cfg_wr_delay | input | DLY_W | Extra clocks before the memory write |
| dreq | input | 1 | Peripheral transfer request |
| refresh_req | input | 1 | Higher-priority refresh request |
| dack | output | 1 | Transfer acknowledge to the peripheral |
| aen | output | 1 | Address-enable flag that silences I/O address decoding |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address counter |
| bytes_left | output | CNT_W | Remaining byte count |
| tc | output | 1 | Terminal-count pulse |
| refresh_gnt | output | 1 | Refresh grant |

## Verification
The hardest cases to reach are a refresh request that lands inside a burst and a request that is withdrawn before it is acknowledged. Both depend on the exact cycle in which the sequencer is idle. The bench waits until it sees dack rise, and only then raises refresh_req, so the request is known to fall inside the burst or byte. For withdrawal, it holds refresh_req high while pulsing dreq, so the request is seen but deferred and then dropped. A reset in the middle of a transfer and a load pulse during an acknowledge are reached the same way, by triggering on the observed rise of dack.

// File: rtl/flyby_pkg.sv
package flyby_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_LEAD,
    ST_HOLD,
    ST_PAIR,
    ST_TAIL
  } seq_state_e;

  typedef enum logic {
    XFER_IO2MEM = 1'b0,
    XFER_MEM2IO = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/flyby_rst_sync.sv
module flyby_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/flyby_addr_cnt.sv
module flyby_addr_cnt #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              step_en,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  count,
  output logic              cnt_zero,
  output logic              cnt_last
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              upd_en;

  always_comb begin
    upd_en = load_en | step_en;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (load_en) begin
      addr_d = load_addr;
      cnt_d  = load_count;
    end else if (step_en) begin
      addr_d = addr_q + ADDR_W'(1);
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr     = addr_q;
  assign count    = cnt_q;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flyby_ctrl.sv
module flyby_ctrl
  import flyby_pkg::*;
#(
  parameter int DLY_W     = 4,
  parameter int BURST_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_dir,
  input  logic             cfg_burst,
  input  logic [DLY_W-1:0] cfg_wr_delay,
  input  logic             dreq,
  input  logic             refresh_req,
  input  logic             cnt_zero,
  input  logic             cnt_last,
  output seq_state_e       state,
  output xfer_dir_e        dir,
  output logic             take_load,
  output logic             step,
  output logic             tc,
  output logic             refresh_gnt
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  seq_state_e       state_q, state_d;
  xfer_dir_e        dir_q;
  logic             burst_q;
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] wait_q, wait_d;
  logic             wait_en;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic             beat_en;
  logic             is_idle;

  assign is_idle   = (state_q == ST_IDLE);
  assign take_load = cfg_load & is_idle;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    wait_en = 1'b0;
    beat_d  = beat_q;
    beat_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (dreq && !refresh_req && !cnt_zero) begin
          state_d = ST_ACK;
          beat_d  = '0;
          beat_en = 1'b1;
        end
      end
      ST_ACK:  state_d = ST_LEAD;
      ST_LEAD: begin
        if (dir_q == XFER_IO2MEM && dly_q != '0) begin
          state_d = ST_HOLD;
          wait_d  = dly_q;
          wait_en = 1'b1;
        end else begin
          state_d = ST_PAIR;
        end
      end
      ST_HOLD: begin
        wait_d  = wait_q - DLY_W'(1);
        wait_en = 1'b1;
        if (wait_q == DLY_W'(1)) state_d = ST_PAIR;
      end
      ST_PAIR: state_d = ST_TAIL;
      ST_TAIL: begin
        if (!cnt_last && burst_q && beat_q != LAST_BEAT) begin
          state_d = ST_LEAD;
          beat_d  = beat_q + BEAT_W'(1);
          beat_en = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= XFER_IO2MEM;
      burst_q <= 1'b0;
      dly_q   <= '0;
    end else if (take_load) begin
      dir_q   <= xfer_dir_e'(cfg_dir);
      burst_q <= cfg_burst;
      dly_q   <= cfg_wr_delay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_q <= '0;
    else if (wait_en) wait_q <= wait_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign state       = state_q;
  assign dir         = dir_q;
  assign step        = (state_q == ST_TAIL);
  assign tc          = step & cnt_last;
  assign refresh_gnt = is_idle & refresh_req;
endmodule

// File: rtl/flyby_strobe.sv
module flyby_strobe
  import flyby_pkg::*;
(
  input  seq_state_e state,
  input  xfer_dir_e  dir,
  output logic       dack,
  output logic       aen,
  output logic       io_rd,
  output logic       io_wr,
  output logic       mem_rd,
  output logic       mem_wr
);
  logic lead_on, trail_on, to_mem;

  always_comb begin
    lead_on  = (state == ST_LEAD) || (state == ST_HOLD) || (state == ST_PAIR);
    trail_on = (state == ST_PAIR);
    to_mem   = (dir == XFER_IO2MEM);
    dack     = (state != ST_IDLE);
    aen      = (state != ST_IDLE);
    io_rd    = to_mem  & lead_on;
    mem_wr   = to_mem  & trail_on;
    mem_rd   = !to_mem & lead_on;
    io_wr    = !to_mem & trail_on;
  end
endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
  import flyby_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 8,
  parameter int DLY_W     = 4,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_dir,
  input  logic              cfg_burst,
  input  logic [DLY_W-1:0]  cfg_wr_delay,
  input  logic              dreq,
  input  logic              refresh_req,
  output logic              dack,
  output logic              aen,
  output logic              io_rd,
  output logic              io_wr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  bytes_left,
  output logic              tc,
  output logic              refresh_gnt
);
  logic       rst_sync_n;
  seq_state_e state;
  xfer_dir_e  dir;
  logic       take_load, step, cnt_zero, cnt_last;

  flyby_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  flyby_ctrl #(.DLY_W(DLY_W), .BURST_LEN(BURST_LEN)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cfg_load     (cfg_load),
    .cfg_dir      (cfg_dir),
    .cfg_burst    (cfg_burst),
    .cfg_wr_delay (cfg_wr_delay),
    .dreq         (dreq),
    .refresh_req  (refresh_req),
    .cnt_zero     (cnt_zero),
    .cnt_last     (cnt_last),
    .state        (state),
    .dir          (dir),
    .take_load    (take_load),
    .step         (step),
    .tc           (tc),
    .refresh_gnt  (refresh_gnt)
  );

  flyby_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_en    (take_load),
    .load_addr  (cfg_addr),
    .load_count (cfg_count),
    .step_en    (step),
    .addr       (mem_addr),
    .count      (bytes_left),
    .cnt_zero   (cnt_zero),
    .cnt_last   (cnt_last)
  );

  flyby_strobe u_stb (
    .state  (state),
    .dir    (dir),
    .dack   (dack),
    .aen    (aen),
    .io_rd  (io_rd),
    .io_wr  (io_wr),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr)
  );
endmodule

// File: rtl/flyby_chk.sv
module flyby_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dack,
  input logic              aen,
  input logic              io_rd,
  input logic              io_wr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              tc,
  input logic              refresh_gnt
);
  logic any_stb;
  assign any_stb = io_rd | io_wr | mem_rd | mem_wr;

  p_memwr_inside_iord_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> io_rd);

  p_memwr_after_iord_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> $past(io_rd));

  p_iowr_one_after_memrd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_wr) |-> (mem_rd && $past(mem_rd)));

  p_iowr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> !io_wr);

  p_stb_under_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> dack);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb && $past(any_stb)) |-> $stable(mem_addr));

  p_aen_covers_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> aen);

  p_drop_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || io_wr) |=> !any_stb);

  p_ack_rise_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack) |-> !any_stb);

  p_ack_fall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dack) |-> $past(!any_stb));

  p_gnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_gnt |-> !dack);

  p_tc_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

  p_tc_under_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (dack && !any_stb));
endmodule

bind flyby_dma_seq flyby_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .dack        (dack),
  .aen         (aen),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_addr    (mem_addr),
  .tc          (tc),
  .refresh_gnt (refresh_gnt)
);

// File: tb/test_flyby_dma_seq.sv
`timescale 1ns/1ps
module test_flyby_dma_seq;
  localparam time CYC = 20ns;

  logic        clk, rst_n;
  logic        cfg_load, cfg_dir, cfg_burst;
  logic [15:0] cfg_addr;
  logic [7:0]  cfg_count;
  logic [3:0]  cfg_wr_delay;
  logic        dreq, refresh_req;
  logic        dack, aen, io_rd, io_wr, mem_rd, mem_wr, tc, refresh_gnt;
  logic [15:0] mem_addr;
  logic [7:0]  bytes_left;

  flyby_dma_seq i_flyby_dma_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_dir(cfg_dir), .cfg_burst(cfg_burst),
    .cfg_wr_delay(cfg_wr_delay), .dreq(dreq), .refresh_req(refresh_req),
    .dack(dack), .aen(aen), .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .bytes_left(bytes_left), .tc(tc),
    .refresh_gnt(refresh_gnt)
  );

  initial clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  typedef struct packed {
    logic        dir;
    logic        blk;
    logic [3:0]  dly;
    logic [7:0]  cnt;
    logic [15:0] addr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'd0,  8'd3,  16'h1000},
    '{1'b0, 1'b0, 4'd3,  8'd2,  16'h2000},
    '{1'b1, 1'b0, 4'd5,  8'd2,  16'h3000},
    '{1'b0, 1'b1, 4'd2,  8'd8,  16'h4000},
    '{1'b1, 1'b1, 4'd0,  8'd11, 16'hFFFC},
    '{1'b0, 1'b1, 4'd1,  8'd16, 16'h0100},
    '{1'b0, 1'b0, 4'd15, 8'd1,  16'hFFFF}
  };

  int checks = 0, errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor
  logic        mon_on = 1'b0;
  logic        cur_dir = 1'b0;
  int          exp_off = 1;
  logic [15:0] base = '0;
  int cyc = 0, t_first = 0;
  int n_bytes, n_acks, n_tc, bad_off, bad_addr, bad_order, gnt_busy, n_gnt;
  logic prev_dack = 1'b0, prev_first = 1'b0;
  logic s_first, s_second;

  task automatic mon_clear();
    n_bytes = 0; n_acks = 0; n_tc = 0; bad_off = 0; bad_addr = 0;
    bad_order = 0; gnt_busy = 0; n_gnt = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    s_first  = cur_dir ? mem_rd : io_rd;
    s_second = cur_dir ? io_wr  : mem_wr;
    if (mon_on) begin
      if (dack && !prev_dack) n_acks++;
      if (s_first && !prev_first) t_first = cyc;
      if (s_second) begin
        if (cyc - t_first != exp_off) bad_off++;
        if (mem_addr != base + 16'(n_bytes)) bad_addr++;
        n_bytes++;
      end
      if (s_second && !s_first) bad_order++;
      if ((io_rd | io_wr | mem_rd | mem_wr) && !dack) bad_order++;
      if (cur_dir ? (io_rd | mem_wr) : (mem_rd | io_wr)) bad_order++;
      if (tc) n_tc++;
      if (refresh_gnt && dack) gnt_busy++;
      if (refresh_gnt) n_gnt++;
    end
    prev_dack  = dack;
    prev_first = s_first;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic load_cfg(input logic d, input logic b, input logic [3:0] dl,
                          input logic [7:0] c, input logic [15:0] a);
    cfg_dir = d; cfg_burst = b; cfg_wr_delay = dl; cfg_count = c; cfg_addr = a;
    cfg_load = 1'b1;
    tick(1);
    cfg_load = 1'b0;
    cur_dir = d; base = a; exp_off = d ? 1 : 1 + int'(dl);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!dack && bytes_left == 8'd0) break;
    end
    tick(3);
  endtask

  task automatic wait_ack_rise();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (dack) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
  endtask

  initial begin
    #(CYC * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    mon_clear();
    cfg_load = 0; cfg_dir = 0; cfg_burst = 0; cfg_wr_delay = 0;
    cfg_count = 0; cfg_addr = 0; dreq = 0; refresh_req = 0;
    rst_n = 1'b0;
    #(CYC * 2 + 5ns);
    // R13: outputs clear during reset
    chk("R13", "dack in reset", int'(dack), 0);
    chk("R13", "strobes in reset", int'(io_rd | io_wr | mem_rd | mem_wr), 0);
    chk("R13", "bytes_left in reset", int'(bytes_left), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R13", "tc after release", int'(tc), 0);

    // vector table: R1 R2 R3 R5 R6 R9 R10
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int exp_acks;
      t = VECS[v];
      load_cfg(t.dir, t.blk, t.dly, t.cnt, t.addr);
      mon_clear();
      mon_on = 1'b1;
      dreq = 1'b1;
      wait_done();
      dreq = 1'b0;
      tick(4);
      mon_on = 1'b0;
      exp_acks = t.blk ? (int'(t.cnt) + 7) / 8 : int'(t.cnt);
      chk("R9",  "bytes moved", n_bytes, int'(t.cnt));
      chk(t.blk ? "R6" : "R5", "acknowledges", n_acks, exp_acks);
      chk(t.dir ? "R2" : "R1", "strobe offset errors", bad_off, 0);
      chk("R9",  "address errors", bad_addr, 0);
      chk("R3",  "strobe order errors", bad_order, 0);
      chk("R10", "tc pulses", n_tc, 1);
      chk("R9",  "final address", int'(mem_addr), int'(16'(t.addr + 16'(t.cnt))));
      chk("R10", "bytes_left end", int'(bytes_left), 0);
    end

    // R10: count zero starts nothing
    load_cfg(1'b0, 1'b0, 4'd0, 8'd0, 16'h5000);
    mon_clear(); mon_on = 1'b1;
    dreq = 1'b1; tick(10); dreq = 1'b0; tick(2);
    mon_on = 1'b0;
    chk("R10", "acks with zero count", n_acks, 0);

    // R11: request withdrawn before acknowledge
    refresh_req = 1'b1;
    load_cfg(1'b0, 1'b0, 4'd0, 8'd2, 16'h6000);
    mon_clear(); mon_on = 1'b1;
    dreq = 1'b1; tick(3); dreq = 1'b0; tick(1);
    refresh_req = 1'b0; tick(10);
    mon_on = 1'b0;
    chk("R11", "acks after withdrawn request", n_acks, 0);
    chk("R11", "bytes_left after withdrawn request", int'(bytes_left), 2);
    chk("R8",  "grant while idle", (n_gnt > 0) ? 1 : 0, 1);

    // R8: refresh raised inside a burst waits for its end
    load_cfg(1'b0, 1'b1, 4'd0, 8'd8, 16'h7000);
    mon_clear(); mon_on = 1'b1;
    dreq = 1'b1;
    wait_ack_rise();
    tick(1);
    refresh_req = 1'b1;
    wait_done();
    dreq = 1'b0;
    tick(2);
    mon_on = 1'b0;
    chk("R8", "burst bytes with refresh", n_bytes, 8);
    chk("R8", "burst acks with refresh", n_acks, 1);
    chk("R8", "grant during ack", gnt_busy, 0);
    chk("R8", "grant after burst", int'(refresh_gnt), 1);
    refresh_req = 1'b0;
    tick(2);

    // R8 R5: refresh in single mode is served at the byte boundary
    load_cfg(1'b1, 1'b0, 4'd0, 8'd3, 16'h8000);
    mon_clear(); mon_on = 1'b1;
    dreq = 1'b1;
    wait_ack_rise();
    tick(1);
    refresh_req = 1'b1;
    tick(12);
    chk("R8", "bytes_left while refresh held", int'(bytes_left), 2);
    chk("R8", "dack while refresh held", int'(dack), 0);
    chk("R8", "grant at byte boundary", int'(refresh_gnt), 1);
    refresh_req = 1'b0;
    wait_done();
    dreq = 1'b0;
    tick(2);
    mon_on = 1'b0;
    chk("R5", "single bytes after refresh", n_bytes, 3);
    chk("R8", "grant during ack single", gnt_busy, 0);

    // R12: load during a transfer is ignored
    load_cfg(1'b0, 1'b0, 4'd0, 8'd4, 16'h9000);
    mon_clear(); mon_on = 1'b1;
    dreq = 1'b1;
    wait_ack_rise();
    cfg_count = 8'd50; cfg_addr = 16'h1234; cfg_load = 1'b1;
    tick(1);
    cfg_load = 1'b0;
    wait_done();
    dreq = 1'b0;
    tick(2);
    mon_on = 1'b0;
    chk("R12", "bytes after busy load", n_bytes, 4);
    chk("R12", "address after busy load", int'(mem_addr), 16'h9004);
    chk("R12", "address errors busy load", bad_addr, 0);

    // R13: reset in the middle of a transfer
    load_cfg(1'b0, 1'b1, 4'd3, 8'd20, 16'hA000);
    dreq = 1'b1;
    wait_ack_rise();
    tick(1);
    rst_n = 1'b0;
    #3;
    chk("R13", "dack at mid reset", int'(dack), 0);
    chk("R13", "io_rd at mid reset", int'(io_rd), 0);
    chk("R13", "bytes_left at mid reset", int'(bytes_left), 0);
    dreq = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(4);
    chk("R13", "dack after mid reset", int'(dack), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule